// File: doc/BRIEF.md
# Stack-Top Word Exchange Sequencer

This block swaps a 16-bit register pair with the 16-bit word at the top of a byte-wide stack in memory. A processor core pulses `start` in the first clock of the instruction's opcode fetch. The sequencer waits out the fetch cycle, which it only counts. It then reads the two stack bytes into a temporary pair and writes the register bytes back high byte first. Once the last write ends, it loads the temporary pair into the register pair.

The sequence has five machine cycles, and one clock is one T-state. The cycles last 4, 3, 4, 3 and 5 clocks: fetch, low-byte read, high-byte read, high-byte write, low-byte write. The working stack pointer is incremented after the first read and decremented after the first write. It therefore ends at its starting value, and the old register pair is left in memory in little-endian order.

Top module: `stk_xchg_seq`

## Requirements
- R1: While the synchronous active-high reset is high, and in the cycle after it is released, `busy`, `done`, `mem_rd` and `mem_wr` are low, and `sp_o`, `pair_o`, `mem_addr` and `mem_wdata` are zero. A reset raised during a sequence returns the block to this idle state on the next clock.
- R2: A `start` seen high at a clock edge while idle raises `busy` from the next cycle for exactly 19 cycles. `done` is high for exactly the one cycle in which `busy` has just fallen.
- R3: During the first 4 busy cycles (the fetch), `mem_rd` and `mem_wr` are low and `mem_addr` is zero.
- R4: Busy cycles 5 to 7 drive `mem_rd` high with `mem_addr` equal to the stack pointer sampled at start (SP). The byte present on `mem_rdata` in cycle 7 becomes the low byte of the temporary pair. `sp_o` reads SP up to this point and SP+1 from busy cycle 8 on, wrapping modulo 2^16.
- R5: Busy cycles 8 to 11 drive `mem_rd` high with `mem_addr` equal to SP+1. The byte present in cycle 11 becomes the high byte of the temporary pair.
- R6: Busy cycles 12 to 14 drive `mem_addr` equal to SP+1 and `mem_wdata` equal to `pair_i[15:8]`. `mem_wr` is high only in cycle 13. `sp_o` returns to SP from busy cycle 15 on.
- R7: Busy cycles 15 to 19 drive `mem_addr` equal to SP and `mem_wdata` equal to `pair_i[7:0]`. `mem_wr` is high only in cycle 16.
- R8: In the `done` cycle, `pair_o` equals {byte read in R5, byte read in R4}, `sp_o` equals SP, and memory holds `pair_i[7:0]` at SP and `pair_i[15:8]` at SP+1.
- R9: A `start` pulse while `busy` is ignored. The running sequence keeps its timing, addresses and data, and no new sequence follows it. `sp_i` and `pair_i` are sampled only on the accepted start.
- R10: `mem_rd` and `mem_wr` are never high together, and `mem_wr` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse in the first T-state of the opcode fetch |
| sp_i | input | 16 | Stack pointer value sampled on an accepted start |
| pair_i | input | 16 | Register pair value sampled on an accepted start |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse when `pair_o` is updated |
| sp_o | output | 16 | Working stack pointer |
| pair_o | output | 16 | Register pair result, updated with `done` |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe, one T-state per write cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, sampled in the last T-state of a read cycle |

## Verification
A wrong T-state count or a wrong machine-cycle successor moves every later strobe. It shows as `mem_rd`, `mem_wr` or `mem_addr` differing from the fixed schedule in the very cycle the error occurs. A wrong step on the working stack pointer shows at once on `sp_o` and on `mem_addr` in the next bus cycle. Bytes captured in the wrong slot, or an operand latched at the wrong time, stay hidden until the `done` cycle. There they show as a wrong `pair_o` or wrong memory contents at SP and SP+1.

// File: rtl/stk_xchg_pkg.sv
package stk_xchg_pkg;

  // Machine-cycle phases of one exchange, in bus order.
  typedef enum logic [2:0] {
    MC_IDLE  = 3'd0,
    MC_FETCH = 3'd1,
    MC_RD_LO = 3'd2,
    MC_RD_HI = 3'd3,
    MC_WR_HI = 3'd4,
    MC_WR_LO = 3'd5
  } mcyc_e;

  function automatic mcyc_e mcyc_succ(mcyc_e m);
    case (m)
      MC_FETCH: return MC_RD_LO;
      MC_RD_LO: return MC_RD_HI;
      MC_RD_HI: return MC_WR_HI;
      MC_WR_HI: return MC_WR_LO;
      default:  return MC_IDLE;
    endcase
  endfunction

  function automatic logic mcyc_is_read(mcyc_e m);
    return (m == MC_RD_LO) || (m == MC_RD_HI);
  endfunction

  function automatic logic mcyc_is_write(mcyc_e m);
    return (m == MC_WR_HI) || (m == MC_WR_LO);
  endfunction

endpackage

// File: rtl/stk_xchg_timer.sv
module stk_xchg_timer
  import stk_xchg_pkg::*;
#(
  parameter int T_FETCH = 4,
  parameter int T_RD_LO = 3,
  parameter int T_RD_HI = 4,
  parameter int T_WR_HI = 3,
  parameter int T_WR_LO = 5,
  parameter int TW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output mcyc_e         mc_q,
  output mcyc_e         mc_d,
  output logic [TW-1:0] ts_d,
  output logic          last_q
);

  logic [TW-1:0] ts_q;

  function automatic logic [TW-1:0] len_of(mcyc_e m);
    case (m)
      MC_FETCH: return TW'(T_FETCH);
      MC_RD_LO: return TW'(T_RD_LO);
      MC_RD_HI: return TW'(T_RD_HI);
      MC_WR_HI: return TW'(T_WR_HI);
      MC_WR_LO: return TW'(T_WR_LO);
      default:  return '0;
    endcase
  endfunction

  // Last T-state of the current machine cycle.
  always_comb last_q = (mc_q != MC_IDLE) && (ts_q == len_of(mc_q));

  always_comb begin
    mc_d = mc_q;
    ts_d = ts_q;
    if (mc_q == MC_IDLE) begin
      if (start) begin
        mc_d = MC_FETCH;
        ts_d = TW'(1);
      end else begin
        ts_d = '0;
      end
    end else if (last_q) begin
      mc_d = mcyc_succ(mc_q);
      ts_d = (mcyc_succ(mc_q) == MC_IDLE) ? '0 : TW'(1);
    end else begin
      ts_d = ts_q + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q <= MC_IDLE;
      ts_q <= '0;
    end else begin
      mc_q <= mc_d;
      ts_q <= ts_d;
    end
  end

endmodule

// File: rtl/stk_xchg_path.sv
module stk_xchg_path
  import stk_xchg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [AW-1:0] sp_i,
  input  logic [2*DW-1:0] pair_i,
  input  mcyc_e         mc_q,
  input  logic          last_q,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] sp_d,
  output logic [DW-1:0] hold_hi,
  output logic [DW-1:0] hold_lo,
  output logic [DW-1:0] tmp_hi,
  output logic [DW-1:0] tmp_lo
);

  logic end_rd_lo, end_rd_hi, end_wr_hi;

  always_comb begin
    end_rd_lo = (mc_q == MC_RD_LO) && last_q;
    end_rd_hi = (mc_q == MC_RD_HI) && last_q;
    end_wr_hi = (mc_q == MC_WR_HI) && last_q;
  end

  // Working stack pointer: step up after the low read, back after the high write.
  always_comb begin
    if (accept)         sp_d = sp_i;
    else if (end_rd_lo) sp_d = sp_q + AW'(1);
    else if (end_wr_hi) sp_d = sp_q - AW'(1);
    else                sp_d = sp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '0;
      hold_hi <= '0;
      hold_lo <= '0;
      tmp_hi  <= '0;
      tmp_lo  <= '0;
    end else begin
      sp_q <= sp_d;
      if (accept) begin
        hold_hi <= pair_i[2*DW-1:DW];
        hold_lo <= pair_i[DW-1:0];
      end
      if (end_rd_lo) tmp_lo <= mem_rdata;
      if (end_rd_hi) tmp_hi <= mem_rdata;
    end
  end

endmodule

// File: rtl/stk_xchg_seq.sv
module stk_xchg_seq
  import stk_xchg_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int T_FETCH   = 4,
  parameter int T_RD_LO   = 3,
  parameter int T_RD_HI   = 4,
  parameter int T_WR_HI   = 3,
  parameter int T_WR_LO   = 5,
  parameter int WR_TSTATE = 2   // must not exceed T_WR_HI or T_WR_LO
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   sp_i,
  input  logic [2*DW-1:0] pair_i,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   sp_o,
  output logic [2*DW-1:0] pair_o,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);

  localparam int TM_A = (T_FETCH > T_RD_LO) ? T_FETCH : T_RD_LO;
  localparam int TM_B = (T_RD_HI > T_WR_HI) ? T_RD_HI : T_WR_HI;
  localparam int TM_C = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int TMAX = (TM_C > T_WR_LO) ? TM_C : T_WR_LO;
  localparam int TW   = $clog2(TMAX + 1);

  mcyc_e         mc_q, mc_d;
  logic [TW-1:0] ts_d;
  logic          last_q, accept, seq_end;
  logic [AW-1:0] sp_q, sp_d;
  logic [DW-1:0] hold_hi, hold_lo, tmp_hi, tmp_lo;

  always_comb begin
    accept  = start && (mc_q == MC_IDLE);
    seq_end = (mc_q == MC_WR_LO) && last_q;
  end

  stk_xchg_timer #(
    .T_FETCH(T_FETCH), .T_RD_LO(T_RD_LO), .T_RD_HI(T_RD_HI),
    .T_WR_HI(T_WR_HI), .T_WR_LO(T_WR_LO), .TW(TW)
  ) u_timer (
    .clk(clk), .rst(rst), .start(start),
    .mc_q(mc_q), .mc_d(mc_d), .ts_d(ts_d), .last_q(last_q)
  );

  stk_xchg_path #(.AW(AW), .DW(DW)) u_path (
    .clk(clk), .rst(rst), .accept(accept), .sp_i(sp_i), .pair_i(pair_i),
    .mc_q(mc_q), .last_q(last_q), .mem_rdata(mem_rdata),
    .sp_q(sp_q), .sp_d(sp_d), .hold_hi(hold_hi), .hold_lo(hold_lo),
    .tmp_hi(tmp_hi), .tmp_lo(tmp_lo)
  );

  assign sp_o = sp_q;

  // Bus outputs are registered from the next machine-cycle state.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      pair_o    <= '0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      busy     <= (mc_d != MC_IDLE);
      done     <= seq_end;
      mem_rd   <= mcyc_is_read(mc_d);
      mem_wr   <= mcyc_is_write(mc_d) && (ts_d == TW'(WR_TSTATE));
      mem_addr <= (mcyc_is_read(mc_d) || mcyc_is_write(mc_d)) ? sp_d : '0;
      case (mc_d)
        MC_WR_HI: mem_wdata <= hold_hi;
        MC_WR_LO: mem_wdata <= hold_lo;
        default:  mem_wdata <= '0;
      endcase
      if (seq_end) pair_o <= {tmp_hi, tmp_lo};
    end
  end

endmodule

// File: rtl/stk_xchg_chk.sv
module stk_xchg_chk #(
  parameter int AW    = 16,
  parameter int TOTAL = 19,
  parameter int LEAD  = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [AW-1:0] sp_i,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] sp_o,
  input logic          mem_rd,
  input logic          mem_wr
);

  localparam int CW = $clog2(TOTAL + 2);

  logic [CW-1:0] run_cnt;
  logic [AW-1:0] sp_start;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else              run_cnt <= run_cnt + CW'(1);
    if (rst)                 sp_start <= '0;
    else if (start && !busy) sp_start <= sp_i;
  end

  a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r10_wr_single: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r2_run_length: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_cnt == CW'(TOTAL)));

  a_r3_quiet_fetch: assert property (@(posedge clk) disable iff (rst)
    (busy && run_cnt < CW'(LEAD)) |-> (!mem_rd && !mem_wr));

  a_r8_sp_restored: assert property (@(posedge clk) disable iff (rst)
    done |-> (sp_o == sp_start));

endmodule

bind stk_xchg_seq stk_xchg_chk #(
  .AW(AW),
  .TOTAL(T_FETCH + T_RD_LO + T_RD_HI + T_WR_HI + T_WR_LO),
  .LEAD(T_FETCH)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .sp_i(sp_i), .busy(busy),
  .done(done), .sp_o(sp_o), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/stk_xchg_seq_test.sv
module stk_xchg_seq_test;

  localparam int TOT = 19;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] sp_i = '0, pair_i = '0;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] sp_o, pair_o, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  mem [256];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stk_xchg_seq uut (
    .clk(clk), .rst(rst), .start(start), .sp_i(sp_i), .pair_i(pair_i),
    .busy(busy), .done(done), .sp_o(sp_o), .pair_o(pair_o),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(busy == 1'b0 && done == 1'b0, req, "busy/done idle", {busy, done}, 0);
    chk(mem_rd == 1'b0 && mem_wr == 1'b0, req, "strobes idle", {mem_rd, mem_wr}, 0);
    chk(sp_o == 16'h0 && pair_o == 16'h0, req, "sp_o/pair_o cleared", {sp_o, pair_o}, 0);
    chk(mem_addr == 16'h0 && mem_wdata == 8'h0, req, "addr/wdata cleared",
        {mem_addr, mem_wdata}, 0);
  endtask

  // Run one exchange; inject >= 0 pulses start while busy, rst_at >= 0 resets mid-run.
  task automatic run(input logic [15:0] sp, input logic [15:0] pr,
                     input logic [7:0] zb, input logic [7:0] wb,
                     input int inject, input int rst_at);
    logic [15:0] sp1;
    sp1 = sp + 16'd1;
    mem[sp[7:0]]  = zb;
    mem[sp1[7:0]] = wb;
    @(negedge clk);
    start = 1'b1; sp_i = sp; pair_i = pr;
    @(negedge clk);
    start = 1'b0; sp_i = ~sp; pair_i = ~pr;
    for (int c = 0; c < TOT; c++) begin
      int ph;
      string rq;
      logic exp_rd, exp_wr;
      logic [15:0] exp_addr, exp_sp;
      logic [7:0] exp_wd;
      if (c > 0) @(negedge clk);
      start = (c == inject);
      if (c == rst_at) begin
        rst = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1");
        return;
      end
      ph = (c < 4) ? 1 : (c < 7) ? 2 : (c < 11) ? 3 : (c < 14) ? 4 : 5;
      case (ph)
        1: rq = "R3"; 2: rq = "R4"; 3: rq = "R5"; 4: rq = "R6"; default: rq = "R7";
      endcase
      exp_rd   = (ph == 2 || ph == 3);
      exp_wr   = (c == 12 || c == 15);
      exp_addr = (ph == 2 || ph == 5) ? sp : (ph == 3 || ph == 4) ? sp1 : 16'h0;
      exp_wd   = (ph == 4) ? pr[15:8] : (ph == 5) ? pr[7:0] : 8'h0;
      exp_sp   = (ph == 3 || ph == 4) ? sp1 : sp;
      chk(busy == 1'b1 && done == 1'b0, "R2", "busy during run", {busy, done}, 2);
      chk(mem_rd == exp_rd, rq, "mem_rd", mem_rd, exp_rd);
      chk(mem_wr == exp_wr, rq, "mem_wr", mem_wr, exp_wr);
      chk(mem_addr == exp_addr, rq, "mem_addr", mem_addr, exp_addr);
      chk(mem_wdata == exp_wd, rq, "mem_wdata", mem_wdata, exp_wd);
      chk(sp_o == exp_sp, (ph == 5 || ph == 4) ? "R6" : "R4", "sp_o", sp_o, exp_sp);
      chk(!(mem_rd && mem_wr), "R10", "rd and wr together", {mem_rd, mem_wr}, 0);
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R2", "done cycle", {busy, done}, 1);
    chk(pair_o == {wb, zb}, "R8", "pair_o", pair_o, {wb, zb});
    chk(sp_o == sp, "R8", "sp_o restored", sp_o, sp);
    chk(mem[sp[7:0]] == pr[7:0], "R8", "mem[SP]", mem[sp[7:0]], pr[7:0]);
    chk(mem[sp1[7:0]] == pr[15:8], "R8", "mem[SP+1]", mem[sp1[7:0]], pr[15:8]);
    @(negedge clk);
    chk(done == 1'b0, "R2", "done single cycle", done, 0);
    chk(busy == 1'b0, inject >= 0 ? "R9" : "R2", "no restart", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'(a);
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    // Sweep stack pointers, pair values and stack contents.
    for (int i = 0; i < 12; i++) begin
      run(16'(i * 5471 + 65530), 16'((i * 40503) ^ 16'hA5C3),
          8'(i * 37 + 3), 8'(i * 91 + 200), -1, -1);
    end
    run(16'hFFFF, 16'h1234, 8'hC7, 8'h2E, -1, -1);   // R4 wrap of SP+1
    run(16'h0000, 16'hFF00, 8'h00, 8'hFF, -1, -1);
    run(16'h40F0, 16'hBEEF, 8'h11, 8'h99, 5, -1);    // R9 start while busy
    run(16'h7788, 16'h5A5A, 8'h66, 8'h44, 17, -1);   // R9 late start
    run(16'h2222, 16'h3333, 8'h44, 8'h55, -1, 13);   // R1 reset mid-run
    run(16'h2222, 16'h3333, 8'h44, 8'h55, -1, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule